// File: doc/BRIEF.md
# Supply Start-Up Sequencer with Reset Output

This block brings a group of on-chip supplies up in a fixed order after the main supply rises, and drives an active-low reset output for the rest of the system. When the main supply first rises past its upper threshold, the block samples a 2-bit start-up code once. It then turns on the charge pump and waits a fixed number of slow ticks. Next it turns on converter B and the LDO that tracks it. If the code selects it, converter C follows after a second delay of the same length. The reset output releases a fixed number of ticks after converter B comes up. If the code selects no converter, only a longer release timer runs. Undervoltage and overvoltage supervision, and overcurrent supervision on the LDO, are masked as long as the reset output is low.

A drop below the lower supply threshold turns everything off and pulls reset low. When the supply recovers, the sequence starts again at the charge-pump step, using the code captured at first start-up. The external reset input must stay low for a deglitch window before it pulls the reset output low. An optional extra delay can be added before that assertion. After the sequence completes, software can load converter enables. Converter A then runs only while its local control input is low. The design has no data stream, so all pins are plain control and status levels. All timing runs from `tick_i`, which is one pulse per millisecond in the target system.

Top module: `supply_seq`

## Requirements
- R1: The start-up code is sampled on the clock after the first rise of `vm_hi_i` that follows `rst_n` release. Later changes on `sel_code_i` have no effect until the next `rst_n`. The code values are: 2'b00 selects no converter, 2'b01 selects B only, and 2'b10 or 2'b11 selects B and then C.
- R2: `cp_en_o` goes high one clock after the capture clock. It is low whenever the sequencer is off. No converter enable is ever high while `cp_en_o` is low.
- R3: Converter B (`dcdc_en_o[1]`) and `ldo_en_o` go high STEP_TICKS ticks after `cp_en_o` rises.
- R4: Under the B-and-C code, converter C (`dcdc_en_o[2]`) goes high STEP_TICKS ticks after B. Under the B-only code, C stays low.
- R5: `nreset_o` goes high REL_TICKS ticks after converter B rises.
- R6: Under the no-converter code, the charge pump turns on, no converter is enabled, and `nreset_o` goes high EMPTY_TICKS ticks after `cp_en_o` rises.
- R7: `mask_o` is high whenever `nreset_o` is low, including during reset.
- R8: `vm_lo_i` has priority over every other input. On the clock after it is seen, the pump, all converters and the LDO turn off and `nreset_o` goes low. When `vm_hi_i` returns, `cp_en_o` rises on the next clock with no capture step, and the timing of R3 to R5 repeats.
- R9: The sequence timers advance only on clocks where `tick_i` is high. While `tick_i` is low, every pending step waits.
- R10: `nreset_o` goes low DG_CYC clocks after `ext_rst_n_i` goes low and stays low, and goes high one clock after `ext_rst_n_i` returns high. A low pulse shorter than DG_CYC clocks has no effect.
- R11: When `dly_opt_i` is high, an extra ADLY_CYC clocks are added before `nreset_o` is pulled low by the external reset. An external low pulse shorter than DG_CYC+ADLY_CYC clocks then has no effect.
- R12: After the sequence has completed, a `reg_load_i` pulse stores `reg_en_i`, where bit 0 is A, bit 1 is B and bit 2 is C. On the next clock the converter enables follow the stored bits, and `ldo_en_o` follows B.
- R13: Converter A is high only under a register request while `a_ctl_i` is low. A change on `a_ctl_i` reaches `dcdc_en_o[0]` one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| tick_i | input | 1 | Slow time-base pulse that advances the sequence timers |
| vm_hi_i | input | 1 | Main supply is above its upper threshold |
| vm_lo_i | input | 1 | Main supply is below its lower threshold |
| sel_code_i | input | 2 | Decoded start-up selection code |
| ext_rst_n_i | input | 1 | External reset request, active low |
| dly_opt_i | input | 1 | Adds the extra assertion delay for external reset |
| reg_load_i | input | 1 | One-clock strobe that loads the converter enable bits |
| reg_en_i | input | 3 | Requested enables for converters A, B and C |
| a_ctl_i | input | 1 | Local control for converter A; low allows A to run |
| cp_en_o | output | 1 | Charge-pump enable |
| dcdc_en_o | output | 3 | Converter enables: bit 0 is A, bit 1 is B, bit 2 is C |
| ldo_en_o | output | 1 | LDO enable |
| mask_o | output | 1 | Supervision mask for UV, OV and LDO overcurrent |
| nreset_o | output | 1 | Reset output, active low |

## Verification
Every output change has a fixed due cycle, counted from the clock that first samples the stimulus. The charge pump turns on one clock after capture. B turns on STEP_TICKS clocks later (with ticks every clock) plus the number of clocks the tick is held low. C follows STEP_TICKS after B, and release follows REL_TICKS after B. The external reset takes DG_CYC or DG_CYC+ADLY_CYC clocks to assert and one clock to release, and register and control changes show one clock later. For each stimulus the driver pushes the expected output pattern and its due clock into a queue. A monitor samples on the falling edge, and at every change on the outputs it pops one entry and compares both the pattern and the clock. A change that no entry expected is therefore reported as well. Glitches and ignored inputs are checked by confirming that no change arrives.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_CAPT  = 3'd1,
    ST_CPW   = 3'd2,
    ST_HOLD  = 3'd3,
    ST_EMPTY = 3'd4,
    ST_RUN   = 3'd5
  } seq_state_e;

  localparam logic [1:0] CODE_NONE = 2'b00;

  function automatic logic code_has_b(input logic [1:0] code);
    return code != CODE_NONE;
  endfunction

  function automatic logic code_has_c(input logic [1:0] code);
    return code[1];
  endfunction

endpackage

// File: rtl/sseq_timer_fsm.sv
module sseq_timer_fsm
  import sseq_pkg::*;
#(
  parameter int STEP_TICKS  = 10,
  parameter int REL_TICKS   = 120,
  parameter int EMPTY_TICKS = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       vm_hi_i,
  input  logic       vm_lo_i,
  input  logic [1:0] sel_code_i,
  output seq_state_e state_o,
  output logic [1:0] code_o,
  output logic       c_due_o
);

  localparam int MAX_T = (EMPTY_TICKS > REL_TICKS) ?
                         ((EMPTY_TICKS > STEP_TICKS) ? EMPTY_TICKS : STEP_TICKS) :
                         ((REL_TICKS > STEP_TICKS) ? REL_TICKS : STEP_TICKS);
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] STEP_LAST  = CNT_W'(STEP_TICKS - 1);
  localparam logic [CNT_W-1:0] REL_LAST   = CNT_W'(REL_TICKS - 1);
  localparam logic [CNT_W-1:0] EMPTY_LAST = CNT_W'(EMPTY_TICKS - 1);
  localparam logic [CNT_W-1:0] STEP_CNT   = CNT_W'(STEP_TICKS);

  seq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       code_q;
  logic             cap_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_OFF;
      cnt_q      <= '0;
      code_q     <= CODE_NONE;
      cap_done_q <= 1'b0;
    end else if (vm_lo_i) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          if (vm_hi_i) begin
            cnt_q <= '0;
            if (!cap_done_q)                 st_q <= ST_CAPT;
            else if (code_has_b(code_q))     st_q <= ST_CPW;
            else                             st_q <= ST_EMPTY;
          end
        end
        ST_CAPT: begin
          code_q     <= sel_code_i;
          cap_done_q <= 1'b1;
          cnt_q      <= '0;
          st_q       <= code_has_b(sel_code_i) ? ST_CPW : ST_EMPTY;
        end
        ST_CPW: begin
          if (tick_i) begin
            if (cnt_q == STEP_LAST) begin
              st_q  <= ST_HOLD;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (tick_i) begin
            if (cnt_q == REL_LAST) begin
              st_q  <= ST_RUN;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_EMPTY: begin
          if (tick_i) begin
            if (cnt_q == EMPTY_LAST) begin
              st_q  <= ST_RUN;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign state_o = st_q;
  assign code_o  = code_q;
  assign c_due_o = (st_q == ST_HOLD) && (cnt_q >= STEP_CNT) && code_has_c(code_q);

  AST_CODE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_done_q && $past(cap_done_q)) |-> $stable(code_q)); // R1

  AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !vm_lo_i && (st_q == ST_CPW || st_q == ST_HOLD || st_q == ST_EMPTY))
      |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/sseq_rst_filter.sv
module sseq_rst_filter #(
  parameter int DG_CYC   = 4,
  parameter int ADLY_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_rst_n_i,
  input  logic dly_opt_i,
  output logic ext_act_o
);

  localparam int DG_W = $clog2(DG_CYC + 1);
  localparam int AD_W = $clog2(ADLY_CYC + 1);
  localparam logic [DG_W-1:0] DG_LAST = DG_W'(DG_CYC - 1);
  localparam logic [AD_W-1:0] AD_LAST = AD_W'(ADLY_CYC - 1);

  logic [DG_W-1:0] dg_q;
  logic [AD_W-1:0] ad_q;
  logic            hit_q;
  logic            late_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dg_q   <= '0;
      ad_q   <= '0;
      hit_q  <= 1'b0;
      late_q <= 1'b0;
    end else if (ext_rst_n_i) begin
      dg_q   <= '0;
      ad_q   <= '0;
      hit_q  <= 1'b0;
      late_q <= 1'b0;
    end else begin
      if (!hit_q) begin
        if (dg_q == DG_LAST) hit_q <= 1'b1;
        else                 dg_q  <= dg_q + 1'b1;
      end else if (!late_q) begin
        if (ad_q == AD_LAST) late_q <= 1'b1;
        else                 ad_q   <= ad_q + 1'b1;
      end
    end
  end

  assign ext_act_o = dly_opt_i ? late_q : hit_q;

  AST_DEGLITCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_q) |-> $past(!ext_rst_n_i)); // R10

  AST_DELAY_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_q) |-> $past(hit_q)); // R11

endmodule

// File: rtl/sseq_chan_mux.sv
module sseq_chan_mux
  import sseq_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  seq_state_e     state_i,
  input  logic [1:0]     code_i,
  input  logic           c_due_i,
  input  logic           reg_load_i,
  input  logic [NCH-1:0] reg_en_i,
  input  logic           a_ctl_i,
  output logic [NCH-1:0] en_o,
  output logic           ldo_o,
  output logic           cp_o
);

  logic [NCH-1:0] reg_q;
  logic           reg_mode_q;
  logic           a_ctl_q;
  logic           run;
  logic [NCH-1:0] seq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q      <= '0;
      reg_mode_q <= 1'b0;
      a_ctl_q    <= 1'b1;
    end else begin
      a_ctl_q <= a_ctl_i;
      if (reg_load_i) begin
        reg_q      <= reg_en_i;
        reg_mode_q <= 1'b1;
      end
    end
  end

  assign run  = (state_i == ST_RUN);
  assign cp_o = (state_i != ST_OFF) && (state_i != ST_CAPT);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (i == 0) begin : g_a
      assign seq_en[i] = 1'b0;
      assign en_o[i]   = run && reg_mode_q && reg_q[i] && !a_ctl_q;
    end else if (i == 1) begin : g_b
      assign seq_en[i] = ((state_i == ST_HOLD) || run) && code_has_b(code_i);
      assign en_o[i]   = (run && reg_mode_q) ? reg_q[i] : seq_en[i];
    end else begin : g_c
      assign seq_en[i] = c_due_i || (run && code_has_c(code_i));
      assign en_o[i]   = (run && reg_mode_q) ? reg_q[i] : seq_en[i];
    end
  end

  assign ldo_o = en_o[1];

  AST_A_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    a_ctl_q |-> !en_o[0]); // R13

  AST_C_AFTER_B: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && en_o[2]) |-> en_o[1]); // R4

endmodule

// File: rtl/supply_seq.sv
module supply_seq
  import sseq_pkg::*;
#(
  parameter int STEP_TICKS  = 10,
  parameter int REL_TICKS   = 120,
  parameter int EMPTY_TICKS = 300,
  parameter int DG_CYC      = 4,
  parameter int ADLY_CYC    = 8,
  parameter int NCH         = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic           vm_hi_i,
  input  logic           vm_lo_i,
  input  logic [1:0]     sel_code_i,
  input  logic           ext_rst_n_i,
  input  logic           dly_opt_i,
  input  logic           reg_load_i,
  input  logic [NCH-1:0] reg_en_i,
  input  logic           a_ctl_i,
  output logic           cp_en_o,
  output logic [NCH-1:0] dcdc_en_o,
  output logic           ldo_en_o,
  output logic           mask_o,
  output logic           nreset_o
);

  seq_state_e state;
  logic [1:0] code;
  logic       c_due;
  logic       ext_act;

  sseq_timer_fsm #(
    .STEP_TICKS (STEP_TICKS),
    .REL_TICKS  (REL_TICKS),
    .EMPTY_TICKS(EMPTY_TICKS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .vm_hi_i   (vm_hi_i),
    .vm_lo_i   (vm_lo_i),
    .sel_code_i(sel_code_i),
    .state_o   (state),
    .code_o    (code),
    .c_due_o   (c_due)
  );

  sseq_rst_filter #(
    .DG_CYC  (DG_CYC),
    .ADLY_CYC(ADLY_CYC)
  ) u_filt (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_rst_n_i(ext_rst_n_i),
    .dly_opt_i  (dly_opt_i),
    .ext_act_o  (ext_act)
  );

  sseq_chan_mux #(
    .NCH(NCH)
  ) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_i   (state),
    .code_i    (code),
    .c_due_i   (c_due),
    .reg_load_i(reg_load_i),
    .reg_en_i  (reg_en_i),
    .a_ctl_i   (a_ctl_i),
    .en_o      (dcdc_en_o),
    .ldo_o     (ldo_en_o),
    .cp_o      (cp_en_o)
  );

  assign nreset_o = (state == ST_RUN) && !ext_act;
  assign mask_o   = (state != ST_RUN) || ext_act;

  AST_PUMP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (|dcdc_en_o) |-> cp_en_o); // R2

  AST_BROWNOUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    vm_lo_i |=> (!nreset_o && !cp_en_o && (dcdc_en_o == '0) && !ldo_en_o)); // R8

  AST_MASK_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !nreset_o |-> mask_o); // R7

endmodule

// File: tb/tb_supply_seq.sv
module tb_supply_seq;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_i;
  logic       vm_hi_i;
  logic       vm_lo_i;
  logic [1:0] sel_code_i;
  logic       ext_rst_n_i;
  logic       dly_opt_i;
  logic       reg_load_i;
  logic [2:0] reg_en_i;
  logic       a_ctl_i;
  logic       cp_en_o;
  logic [2:0] dcdc_en_o;
  logic       ldo_en_o;
  logic       mask_o;
  logic       nreset_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  supply_seq dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .vm_hi_i    (vm_hi_i),
    .vm_lo_i    (vm_lo_i),
    .sel_code_i (sel_code_i),
    .ext_rst_n_i(ext_rst_n_i),
    .dly_opt_i  (dly_opt_i),
    .reg_load_i (reg_load_i),
    .reg_en_i   (reg_en_i),
    .a_ctl_i    (a_ctl_i),
    .cp_en_o    (cp_en_o),
    .dcdc_en_o  (dcdc_en_o),
    .ldo_en_o   (ldo_en_o),
    .mask_o     (mask_o),
    .nreset_o   (nreset_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  int          q_cyc[$];
  logic [6:0]  q_val[$];
  string       q_req[$];
  logic [6:0]  prev_v;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [6:0] vv(input logic cp, input logic a, input logic b,
                                    input logic c, input logic ldo, input logic nr);
    return {cp, a, b, c, ldo, ~nr, nr};
  endfunction

  function automatic logic [6:0] outs();
    return {cp_en_o, dcdc_en_o[0], dcdc_en_o[1], dcdc_en_o[2], ldo_en_o, mask_o, nreset_o};
  endfunction

  task automatic push(input int c, input logic [6:0] v, input string req);
    q_cyc.push_back(c);
    q_val.push_back(v);
    q_req.push_back(req);
  endtask

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs %b, expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Monitor: pops one expected item per observed output change.
  always @(negedge clk) begin
    logic [6:0] cur;
    cur = outs();
    if (!rst_n) begin
      prev_v = cur;
    end else if (cur !== prev_v) begin
      n_cmp++;
      if (q_val.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected change: outputs %b, expected %b (no change) at cycle %0d",
                 cur, prev_v, cyc);
      end else begin
        int         ec;
        logic [6:0] ev;
        string      er;
        ec = q_cyc.pop_front();
        ev = q_val.pop_front();
        er = q_req.pop_front();
        if (ev !== cur || ec != cyc) begin
          n_bad++;
          $display("FAIL %s: outputs %b at cycle %0d, expected %b at cycle %0d",
                   er, cur, cyc, ev, ec);
        end
      end
      prev_v = cur;
    end
  end

  task automatic drain();
    int w;
    w = 0;
    while (q_val.size() != 0 && w < 2000) begin
      @(negedge clk);
      w++;
    end
    n_cmp++;
    if (q_val.size() != 0) begin
      n_bad++;
      $display("FAIL %s: %0d expected changes missing, expected 0 pending", q_req[0], q_val.size());
      q_cyc.delete();
      q_val.delete();
      q_req.delete();
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run still active, expected finish");
    finish_run();
  end

  initial begin
    int t;
    int k;
    rst_n = 1'b0; tick_i = 1'b1; vm_hi_i = 1'b0; vm_lo_i = 1'b1;
    sel_code_i = 2'b10; ext_rst_n_i = 1'b1; dly_opt_i = 1'b0;
    reg_load_i = 1'b0; reg_en_i = 3'b000; a_ctl_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R7", outs(), vv(0, 0, 0, 0, 0, 0));
    rst_n = 1'b1;
    @(negedge clk);

    // B-then-C start-up
    @(negedge clk); t = cyc;
    vm_lo_i = 1'b0; vm_hi_i = 1'b1; k = t + 1;
    push(k + 1,   vv(1, 0, 0, 0, 0, 0), "R2");
    push(k + 11,  vv(1, 0, 1, 0, 1, 0), "R3");
    push(k + 21,  vv(1, 0, 1, 1, 1, 0), "R4");
    push(k + 131, vv(1, 0, 1, 1, 1, 1), "R5");
    drain();

    // Brownout from run
    @(negedge clk); t = cyc;
    vm_lo_i = 1'b1; vm_hi_i = 1'b0;
    push(t + 1, vv(0, 0, 0, 0, 0, 0), "R8");
    drain();

    // Recovery with a new code on the pin (must be ignored), then drop mid-hold
    sel_code_i = 2'b00;
    @(negedge clk); t = cyc;
    vm_lo_i = 1'b0; vm_hi_i = 1'b1; k = t + 1;
    push(k,      vv(1, 0, 0, 0, 0, 0), "R8");
    push(k + 10, vv(1, 0, 1, 0, 1, 0), "R1");
    push(k + 20, vv(1, 0, 1, 1, 1, 0), "R1");
    drain();
    wait_until(k + 50); t = cyc;
    vm_lo_i = 1'b1; vm_hi_i = 1'b0;
    push(t + 1, vv(0, 0, 0, 0, 0, 0), "R8");
    drain();
    @(negedge clk); t = cyc;
    vm_lo_i = 1'b0; vm_hi_i = 1'b1; k = t + 1;
    push(k,       vv(1, 0, 0, 0, 0, 0), "R8");
    push(k + 10,  vv(1, 0, 1, 0, 1, 0), "R3");
    push(k + 20,  vv(1, 0, 1, 1, 1, 0), "R4");
    push(k + 130, vv(1, 0, 1, 1, 1, 1), "R5");
    drain();

    // Register control and channel A gating
    @(negedge clk); t = cyc;
    reg_load_i = 1'b1; reg_en_i = 3'b001;
    push(t + 1, vv(1, 1, 0, 0, 0, 1), "R12");
    @(negedge clk); reg_load_i = 1'b0;
    drain();
    @(negedge clk); t = cyc; a_ctl_i = 1'b1;
    push(t + 1, vv(1, 0, 0, 0, 0, 1), "R13");
    drain();
    @(negedge clk); t = cyc; a_ctl_i = 1'b0;
    push(t + 1, vv(1, 1, 0, 0, 0, 1), "R13");
    drain();
    @(negedge clk); t = cyc;
    reg_load_i = 1'b1; reg_en_i = 3'b110;
    push(t + 1, vv(1, 0, 1, 1, 1, 1), "R12");
    @(negedge clk); reg_load_i = 1'b0;
    drain();

    // External reset: short glitch, then a held request
    @(negedge clk); ext_rst_n_i = 1'b0;
    @(negedge clk);
    @(negedge clk); ext_rst_n_i = 1'b1;
    repeat (5) @(negedge clk);
    check("R10", outs(), vv(1, 0, 1, 1, 1, 1));
    @(negedge clk); t = cyc; ext_rst_n_i = 1'b0;
    push(t + 4, vv(1, 0, 1, 1, 1, 0), "R10");
    drain();
    repeat (3) @(negedge clk);
    t = cyc; ext_rst_n_i = 1'b1;
    push(t + 1, vv(1, 0, 1, 1, 1, 1), "R10");
    drain();

    // Delay option: 6-clock pulse ignored, held request delayed
    @(negedge clk); dly_opt_i = 1'b1;
    @(negedge clk); ext_rst_n_i = 1'b0;
    repeat (6) @(negedge clk);
    ext_rst_n_i = 1'b1;
    repeat (10) @(negedge clk);
    check("R11", outs(), vv(1, 0, 1, 1, 1, 1));
    @(negedge clk); t = cyc; ext_rst_n_i = 1'b0;
    push(t + 12, vv(1, 0, 1, 1, 1, 0), "R11");
    drain();
    @(negedge clk); t = cyc; ext_rst_n_i = 1'b1;
    push(t + 1, vv(1, 0, 1, 1, 1, 1), "R11");
    drain();
    dly_opt_i = 1'b0;

    // No-converter code after a fresh power-on reset
    @(negedge clk);
    rst_n = 1'b0; sel_code_i = 2'b00; vm_lo_i = 1'b1; vm_hi_i = 1'b0; reg_en_i = 3'b000;
    repeat (2) @(negedge clk);
    check("R7", outs(), vv(0, 0, 0, 0, 0, 0));
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk); t = cyc;
    vm_lo_i = 1'b0; vm_hi_i = 1'b1; k = t + 1;
    push(k + 1,   vv(1, 0, 0, 0, 0, 0), "R6");
    push(k + 301, vv(1, 0, 0, 0, 0, 1), "R6");
    drain();

    // B-only code with the tick held low for 5 clocks
    @(negedge clk);
    rst_n = 1'b0; sel_code_i = 2'b01; vm_lo_i = 1'b1; vm_hi_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk); t = cyc;
    vm_lo_i = 1'b0; vm_hi_i = 1'b1; k = t + 1;
    push(k + 1,   vv(1, 0, 0, 0, 0, 0), "R2");
    push(k + 16,  vv(1, 0, 1, 0, 1, 0), "R9");
    push(k + 136, vv(1, 0, 1, 0, 1, 1), "R5");
    wait_until(k + 1);
    tick_i = 1'b0;
    repeat (5) @(negedge clk);
    tick_i = 1'b1;
    drain();
    repeat (30) @(negedge clk);
    check("R4", outs(), vv(1, 0, 1, 0, 1, 1));

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule